// File: doc/BRIEF.md
# PS/2 Keyboard Key-Event Receiver

This block listens to the clock and data wires of a PS/2 keyboard and turns the serial traffic into key events. Both wires arrive unsynchronised and far slower than the system clock. They pass through a two-stage synchroniser, and the clock wire is then debounced by a small filter. Each falling edge of the filtered keyboard clock shifts one data bit into an 11-bit frame. When the last bit of a frame is in, the frame is checked. A correct frame yields one byte. A damaged frame yields an error pulse.

A small decoder tracks the release prefix byte (F0) and the extended prefix byte (E0). A prefix byte produces no output. The first byte that is not a prefix closes the sequence and is reported as a key event. The event carries the 8-bit code plus two flags: one for a released key and one for an extended key. The event valid signal is high for a single system cycle. A host reads the event in that cycle.

If the keyboard clock stops in the middle of a frame, a watchdog counter drops the partly received bits. This lets a keyboard that was unplugged or reset part-way through a frame recover.

Top module: `ps2_kbd_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `ev_vld_o`, `frm_err_o`, `ev_rel_o`, `ev_ext_o` are low and `ev_code_o` is 00.
- R2: A frame is a 0 start bit, then eight data bits least significant first, then a parity bit, then a 1 stop bit. Each bit is sampled on a falling keyboard-clock edge. A good frame carrying any byte other than E0 or F0, with no prefix before it, gives one event: that byte as the code, with both flags low.
- R3: The parity bit makes the count of ones across the data and parity bits odd. A frame whose parity gives an even count raises `frm_err_o` for one cycle and produces no event.
- R4: A frame whose first bit is 1, or whose eleventh bit is 0, raises `frm_err_o` and produces no event.
- R5: The byte F0 produces no event. It makes the next non-prefix code report with `ev_rel_o` high.
- R6: The byte E0 produces no event. It makes the next non-prefix code report with `ev_ext_o` high.
- R7: The sequence E0, F0, code reports that code with both flags high.
- R8: A damaged frame cancels any pending E0 or F0 prefix. The next good code then reports with both flags low.
- R9: `ev_vld_o` is never high on two consecutive cycles. There is exactly one valid cycle per reported event.
- R10: If a frame has started and no falling keyboard-clock edge arrives for `TIMEOUT_CYC` system cycles, the partial frame is dropped without an error. The next complete frame is then received correctly.
- R11: A low pulse on the keyboard clock that lasts fewer than `FILT_LEN` system cycles is not treated as an edge.
- R12: The same code sent repeatedly, as a held key does, gives a separate event each time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Keyboard clock wire, idles high |
| ps2_dat_i | input | 1 | Keyboard data wire, idles high |
| ev_vld_o | output | 1 | One-cycle pulse marking a key event |
| ev_code_o | output | 8 | Scan code of the event |
| ev_rel_o | output | 1 | Event is a key release |
| ev_ext_o | output | 1 | Event is an extended key |
| frm_err_o | output | 1 | One-cycle pulse on a damaged frame |

## Verification
Two situations are hard to reach from the pins. The first is a keyboard clock that stalls part-way through a frame. The bench reaches it by sending only a few bits and then holding both wires idle for longer than the timeout. A frame follows, and it must decode cleanly: if the stale bits had been kept, the frame would come out misaligned. The second is a runt clock pulse. The bench injects a two-cycle low pulse inside every high phase of a frame, and the byte must still come out unchanged.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    localparam int FRAME_BITS = 11;
    localparam logic [7:0] CODE_EXT = 8'hE0;
    localparam logic [7:0] CODE_BRK = 8'hF0;
endpackage

// File: rtl/kbd_line_cond.sv
module kbd_line_cond #(
    parameter int FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ps2_clk_i,
    input  logic ps2_dat_i,
    output logic fall_o,
    output logic dat_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    ck_sync;
        logic [1:0]    dt_sync;
        logic          ck_filt;
        logic [CW-1:0] cnt;
        logic          fall;
    } lc_state_t;

    lc_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.ck_sync = {st_q.ck_sync[0], ps2_clk_i};
        st_d.dt_sync = {st_q.dt_sync[0], ps2_dat_i};
        st_d.fall    = 1'b0;
        if (st_q.ck_sync[1] != st_q.ck_filt) begin
            if (st_q.cnt == CW'(FILT_LEN - 1)) begin
                st_d.ck_filt = st_q.ck_sync[1];
                st_d.cnt     = '0;
                st_d.fall    = st_q.ck_filt;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ck_sync <= 2'b11;
            st_q.dt_sync <= 2'b11;
            st_q.ck_filt <= 1'b1;
            st_q.cnt     <= '0;
            st_q.fall    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o = st_q.fall;
    assign dat_o  = st_q.dt_sync[1];

    AST_FALL_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fall |=> !st_q.fall); // R11
    AST_FILT_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(FILT_LEN)); // R11
endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx
    import kbd_pkg::*;
#(
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fall_i,
    input  logic       dat_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o,
    output logic       err_o
);
    localparam int TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [3:0] LAST_BIT = 4'(FRAME_BITS - 1);

    typedef struct packed {
        logic [3:0]            cnt;
        logic [FRAME_BITS-1:0] sh;
        logic [TW-1:0]         tmr;
        logic                  byte_vld;
        logic                  err;
        logic [7:0]            data;
    } fr_state_t;

    fr_state_t st_d, st_q;
    logic      frame_ok;

    always_comb begin
        st_d          = st_q;
        st_d.byte_vld = 1'b0;
        st_d.err      = 1'b0;
        frame_ok      = 1'b0;
        if (fall_i) begin
            st_d.sh  = {dat_i, st_q.sh[FRAME_BITS-1:1]};
            st_d.tmr = '0;
            if (st_q.cnt == LAST_BIT) begin
                frame_ok      = !st_d.sh[0] && st_d.sh[FRAME_BITS-1] && (^st_d.sh[9:1]);
                st_d.cnt      = '0;
                st_d.data     = st_d.sh[8:1];
                st_d.byte_vld = frame_ok;
                st_d.err      = !frame_ok;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (st_q.cnt != '0) begin
            if (st_q.tmr == TW'(TIMEOUT_CYC - 1)) begin
                st_d.cnt = '0;
                st_d.tmr = '0;
            end else begin
                st_d.tmr = st_q.tmr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_vld_o = st_q.byte_vld;
    assign byte_o     = st_q.data;
    assign err_o      = st_q.err;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_BIT); // R2
    AST_RESULT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.byte_vld || st_q.err) |-> $past(fall_i)); // R2
    AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.byte_vld && st_q.err)); // R3
    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tmr < TW'(TIMEOUT_CYC)); // R10
endmodule

// File: rtl/kbd_event_dec.sv
module kbd_event_dec
    import kbd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld_i,
    input  logic [7:0] byte_i,
    input  logic       err_i,
    output logic       ev_vld_o,
    output logic [7:0] ev_code_o,
    output logic       ev_rel_o,
    output logic       ev_ext_o,
    output logic       err_o
);
    typedef struct packed {
        logic       pend_rel;
        logic       pend_ext;
        logic       vld;
        logic [7:0] code;
        logic       rel;
        logic       ext;
        logic       err;
    } ev_state_t;

    ev_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.err = 1'b0;
        if (err_i) begin
            st_d.err      = 1'b1;
            st_d.pend_rel = 1'b0;
            st_d.pend_ext = 1'b0;
        end else if (byte_vld_i) begin
            if (byte_i == CODE_EXT) begin
                st_d.pend_ext = 1'b1;
            end else if (byte_i == CODE_BRK) begin
                st_d.pend_rel = 1'b1;
            end else begin
                st_d.vld      = 1'b1;
                st_d.code     = byte_i;
                st_d.rel      = st_q.pend_rel;
                st_d.ext      = st_q.pend_ext;
                st_d.pend_rel = 1'b0;
                st_d.pend_ext = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ev_vld_o  = st_q.vld;
    assign ev_code_o = st_q.code;
    assign ev_rel_o  = st_q.rel;
    assign ev_ext_o  = st_q.ext;
    assign err_o     = st_q.err;

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> !st_q.vld); // R9
    AST_VLD_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> $past(byte_vld_i)); // R2
    AST_NO_PREFIX_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> (st_q.code != CODE_EXT && st_q.code != CODE_BRK)); // R5
    AST_ERR_DROPS_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.err |-> (!st_q.pend_rel && !st_q.pend_ext)); // R8
    AST_ERR_NOT_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.err && st_q.vld)); // R3
endmodule

// File: rtl/ps2_kbd_rx.sv
module ps2_kbd_rx #(
    parameter int FILT_LEN    = 8,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic       ev_vld_o,
    output logic [7:0] ev_code_o,
    output logic       ev_rel_o,
    output logic       ev_ext_o,
    output logic       frm_err_o
);
    logic       fall_w;
    logic       dat_w;
    logic       byte_vld_w;
    logic [7:0] byte_w;
    logic       ferr_w;

    kbd_line_cond #(.FILT_LEN(FILT_LEN)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .ps2_clk_i (ps2_clk_i),
        .ps2_dat_i (ps2_dat_i),
        .fall_o    (fall_w),
        .dat_o     (dat_w)
    );

    kbd_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall_w),
        .dat_i      (dat_w),
        .byte_vld_o (byte_vld_w),
        .byte_o     (byte_w),
        .err_o      (ferr_w)
    );

    kbd_event_dec u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld_i (byte_vld_w),
        .byte_i     (byte_w),
        .err_i      (ferr_w),
        .ev_vld_o   (ev_vld_o),
        .ev_code_o  (ev_code_o),
        .ev_rel_o   (ev_rel_o),
        .ev_ext_o   (ev_ext_o),
        .err_o      (frm_err_o)
    );
endmodule

// File: tb/ps2_kbd_rx_test.sv
`timescale 1ns/1ps
module ps2_kbd_rx_test;
    localparam int HALF = 12;
    localparam int FILT = 4;
    localparam int TMO  = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_clk = 1'b1;
    logic       ps2_dat = 1'b1;
    logic       ev_vld;
    logic [7:0] ev_code;
    logic       ev_rel;
    logic       ev_ext;
    logic       frm_err;

    int checks = 0;
    int errors = 0;
    int n_ev = 0;
    int n_err = 0;
    int n_dbl = 0;
    logic       prev_vld = 1'b0;
    logic [7:0] last_code = 8'h00;
    logic       last_rel = 1'b0;
    logic       last_ext = 1'b0;

    always #2.5 clk = ~clk;

    ps2_kbd_rx #(.FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ps2_clk_i (ps2_clk),
        .ps2_dat_i (ps2_dat),
        .ev_vld_o  (ev_vld),
        .ev_code_o (ev_code),
        .ev_rel_o  (ev_rel),
        .ev_ext_o  (ev_ext),
        .frm_err_o (frm_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (ev_vld) begin
                n_ev++;
                last_code = ev_code;
                last_rel  = ev_rel;
                last_ext  = ev_ext;
                if (prev_vld) n_dbl++;
            end
            if (frm_err) n_err++;
            prev_vld = ev_vld;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_par,
                              input bit bad_start, input bit bad_stop,
                              input bit glitch);
        logic [10:0] bits;
        bits = {~bad_stop, (~^b) ^ bad_par, b, bad_start};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            ps2_dat = bits[i];
            repeat (HALF / 2) @(negedge clk);
            if (glitch) begin
                ps2_clk = 1'b0;
                repeat (2) @(negedge clk);
                ps2_clk = 1'b1;
            end
            repeat (HALF / 2) @(negedge clk);
            ps2_clk = 1'b0;
            repeat (HALF) @(negedge clk);
            ps2_clk = 1'b1;
        end
        ps2_dat = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic send_good(input logic [7:0] b);
        send_frame(b, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic expect_event(input string req, input int base,
                                input logic [7:0] code, input bit rel, input bit ext);
        chk(n_ev - base == 1, req, "event count", n_ev - base, 1);
        chk({last_rel, last_ext, last_code} == {rel, ext, code}, req,
            "rel/ext/code", int'({last_rel, last_ext, last_code}), int'({rel, ext, code}));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base;
        int ebase;
        repeat (5) @(negedge clk);
        // R1: outputs quiet during and right after reset
        chk({ev_vld, frm_err, ev_rel, ev_ext, ev_code} == 12'h000, "R1", "in reset",
            int'({ev_vld, frm_err, ev_rel, ev_ext, ev_code}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ev_vld, frm_err, ev_rel, ev_ext, ev_code} == 12'h000, "R1", "after reset",
            int'({ev_vld, frm_err, ev_rel, ev_ext, ev_code}), 0);

        // R2: sweep of every non-prefix byte
        for (int c = 0; c < 256; c++) begin
            if (c != 8'hE0 && c != 8'hF0) begin
                base = n_ev;
                send_good(8'(c));
                expect_event("R2", base, 8'(c), 1'b0, 1'b0);
            end
        end

        // R12: held key repeats
        base = n_ev;
        for (int k = 0; k < 3; k++) send_good(8'h1C);
        chk(n_ev - base == 3, "R12", "repeat events", n_ev - base, 3);

        // R5: release prefix
        base = n_ev;
        send_good(8'hF0);
        chk(n_ev == base, "R5", "no event on F0", n_ev - base, 0);
        send_good(8'h1C);
        expect_event("R5", base, 8'h1C, 1'b1, 1'b0);

        // R6: extended prefix
        base = n_ev;
        send_good(8'hE0);
        chk(n_ev == base, "R6", "no event on E0", n_ev - base, 0);
        send_good(8'h75);
        expect_event("R6", base, 8'h75, 1'b0, 1'b1);

        // R7: extended release over a few codes
        for (int c = 8'h10; c < 8'h80; c += 8'h23) begin
            base = n_ev;
            send_good(8'hE0);
            send_good(8'hF0);
            send_good(8'(c));
            expect_event("R7", base, 8'(c), 1'b1, 1'b1);
        end

        // R3: parity damage
        base = n_ev; ebase = n_err;
        send_frame(8'h2B, 1'b1, 1'b0, 1'b0, 1'b0);
        chk(n_err - ebase == 1, "R3", "error pulses", n_err - ebase, 1);
        chk(n_ev == base, "R3", "no event", n_ev - base, 0);

        // R4: start and stop damage
        base = n_ev; ebase = n_err;
        send_frame(8'h2B, 1'b0, 1'b1, 1'b0, 1'b0);
        chk(n_err - ebase == 1, "R4", "bad start error", n_err - ebase, 1);
        send_frame(8'h2B, 1'b0, 1'b0, 1'b1, 1'b0);
        chk(n_err - ebase == 2, "R4", "bad stop error", n_err - ebase, 2);
        chk(n_ev == base, "R4", "no event", n_ev - base, 0);

        // R8: damaged frame cancels prefixes
        base = n_ev;
        send_good(8'hF0);
        send_frame(8'h33, 1'b1, 1'b0, 1'b0, 1'b0);
        send_good(8'h1C);
        expect_event("R8", base, 8'h1C, 1'b0, 1'b0);
        base = n_ev;
        send_good(8'hE0);
        send_frame(8'h33, 1'b0, 1'b0, 1'b1, 1'b0);
        send_good(8'h74);
        expect_event("R8", base, 8'h74, 1'b0, 1'b0);

        // R10: stalled partial frame then a full frame
        base = n_ev; ebase = n_err;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            ps2_dat = i[0];
            repeat (HALF) @(negedge clk);
            ps2_clk = 1'b0;
            repeat (HALF) @(negedge clk);
            ps2_clk = 1'b1;
        end
        ps2_dat = 1'b1;
        repeat (TMO + 60) @(negedge clk);
        chk(n_err == ebase, "R10", "no error on timeout", n_err - ebase, 0);
        send_good(8'h4D);
        expect_event("R10", base, 8'h4D, 1'b0, 1'b0);
        chk(n_err == ebase, "R10", "no error after resync", n_err - ebase, 0);

        // R11: runt clock pulses inside each high phase
        base = n_ev; ebase = n_err;
        send_frame(8'h5A, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_event("R11", base, 8'h5A, 1'b0, 1'b0);
        chk(n_err == ebase, "R11", "no error", n_err - ebase, 0);

        // R9: never two valid cycles in a row
        chk(n_dbl == 0, "R9", "back-to-back valid", n_dbl, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule